// File: doc/BRIEF.md
# Table Pointer and Latch Unit

This block provides the byte-wide path between a small on-chip program memory and the data side of a microcontroller core. It keeps a 22-bit table pointer and an 8-bit table latch. The core writes the pointer one byte register at a time through a byte-select write port, then issues table operations. A table read copies one program-memory byte into the latch. A table write copies the latch into one of 64 holding registers. A commit copies the whole holding buffer into a 64-byte row of program memory. An erase fills a 1024-byte block with 0xFF.

Table reads and writes carry one of four pointer-update modes. Increment and decrement stay inside the low 21 pointer bits, so the top bit selects a separate address space that the update modes never leave. Each operation decodes its own field of the pointer: reads use every bit, writes into the holding buffer use the low six bits, commits use the row field and erases use the block field. Commits and erases run as multi-cycle sequences and hold a busy flag for as long as they run.

Top module: `tbl_access_unit`

## Requirements
- R1: After a synchronous active-high reset the pointer and the latch read 0, busy is low and all 64 holding registers hold 0xFF.
- R2: A direct write with select code 0, 1 or 2 loads pointer bits 7:0, 15:8 or 21:16 (the low 6 bits of the data) from the data byte; select code 3 loads the latch. The new value is visible on the next clock.
- R3: op_mode selects the pointer update on a read (op_kind 0) or write (op_kind 1): 0 leaves the pointer unchanged, 1 increments after the access, 2 decrements after the access, 3 increments before the access. Post modes access the old pointer; the pre-increment mode accesses the incremented pointer.
- R4: Increment and decrement act on pointer bits 20:0 only; a carry out of bit 20 or a borrow into it wraps within 21 bits, and bit 21 keeps its value.
- R5: A table read loads the latch one clock after the request with the program-memory byte at the access address; every pointer bit takes part in the decode, and an address beyond the implemented 2048 bytes (any of bits 21:11 set) reads 0xFF.
- R6: A table write stores the latch value into the holding register selected by access-address bits 5:0.
- R7: A commit (op_kind 2) copies all 64 holding registers into the row chosen by pointer bits 20:6 as sampled at the start, keeps busy high for 64 clocks, and then sets every holding register back to 0xFF.
- R8: An erase (op_kind 3) sets all 1024 bytes of the block chosen by pointer bits 21:10 to 0xFF, ignores pointer bits 9:0, and keeps busy high for 1024 clocks.
- R9: While busy is high, op_valid is ignored; direct writes to the pointer and latch still take effect.
- R10: When a direct pointer-byte write and an auto-update fall in the same cycle, the written byte takes the data value and the other bytes take the updated value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Direct byte write strobe |
| wr_sel | input | 2 | Direct write target: 0 pointer low, 1 pointer high, 2 pointer upper, 3 latch |
| wr_data | input | 8 | Direct write data |
| op_valid | input | 1 | Table operation request |
| op_kind | input | 2 | 0 read, 1 write, 2 commit, 3 erase |
| op_mode | input | 2 | 0 none, 1 post-increment, 2 post-decrement, 3 pre-increment |
| ptr_o | output | 22 | Current table pointer |
| latch_o | output | 8 | Current table latch |
| busy_o | output | 1 | Commit or erase in progress |

## Verification
The holding buffer has no read port, so its contents and its return to 0xFF after a commit can only be seen by committing it to a row and reading that row back with table reads. The bench fills chosen holding slots through every update mode, commits, reads the row back through the same modes, then commits again with no writes in between and expects the row to return to 0xFF. Out-of-range reads are reached by placing data at a low address and reading it again with bit 21 or bit 11 set, which must give 0xFF rather than the stored byte.

// File: rtl/tpl_pkg.sv
package tpl_pkg;
  typedef enum logic [1:0] {
    OP_READ   = 2'd0,
    OP_WRITE  = 2'd1,
    OP_COMMIT = 2'd2,
    OP_ERASE  = 2'd3
  } op_kind_e;

  typedef enum logic [1:0] {
    UPD_NONE     = 2'd0,
    UPD_POST_INC = 2'd1,
    UPD_POST_DEC = 2'd2,
    UPD_PRE_INC  = 2'd3
  } upd_mode_e;

  typedef enum logic [1:0] {
    SEL_LOW   = 2'd0,
    SEL_HIGH  = 2'd1,
    SEL_UPPER = 2'd2,
    SEL_LATCH = 2'd3
  } byte_sel_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ERASE  = 2'd1,
    ST_COMMIT = 2'd2
  } seq_state_e;
endpackage

// File: rtl/tpl_ptr_step.sv
module tpl_ptr_step
  import tpl_pkg::*;
#(
  parameter int PTR_W = 22
) (
  input  logic [PTR_W-1:0] cur,
  input  upd_mode_e        mode,
  output logic [PTR_W-1:0] acc,
  output logic [PTR_W-1:0] nxt
);
  localparam int LW = PTR_W - 1;

  logic [PTR_W-1:0] inc_v, dec_v;

  // top bit is carried through untouched; arithmetic wraps in LW bits
  assign inc_v = {cur[PTR_W-1], cur[LW-1:0] + LW'(1)};
  assign dec_v = {cur[PTR_W-1], cur[LW-1:0] - LW'(1)};

  always_comb begin
    acc = cur;
    nxt = cur;
    unique case (mode)
      UPD_NONE:     nxt = cur;
      UPD_POST_INC: nxt = inc_v;
      UPD_POST_DEC: nxt = dec_v;
      UPD_PRE_INC: begin
        acc = inc_v;
        nxt = inc_v;
      end
      default:      nxt = cur;
    endcase
  end
endmodule

// File: rtl/tpl_ram.sv
module tpl_ram #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/tpl_hold_buf.sv
module tpl_hold_buf #(
  parameter int IW = 6,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  logic [DW-1:0] wdata,
  input  logic [IW-1:0] ridx,
  output logic [DW-1:0] rdata
);
  localparam int N = 1 << IW;

  logic [DW-1:0] slot [N];

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      for (int i = 0; i < N; i++) slot[i] <= '1;
    end else if (we) begin
      slot[widx] <= wdata;
    end
  end

  assign rdata = slot[ridx];
endmodule

// File: rtl/tbl_access_unit.sv
module tbl_access_unit
  import tpl_pkg::*;
#(
  parameter int PTR_W  = 22,
  parameter int DW     = 8,
  parameter int MEM_AW = 11,
  parameter int ROW_AW = 6,
  parameter int BLK_AW = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [7:0]       wr_data,
  input  logic             op_valid,
  input  logic [1:0]       op_kind,
  input  logic [1:0]       op_mode,
  output logic [PTR_W-1:0] ptr_o,
  output logic [DW-1:0]    latch_o,
  output logic             busy_o
);
  localparam int UP_W      = PTR_W - 16;
  localparam int ROW_BYTES = 1 << ROW_AW;
  localparam int BLK_BYTES = 1 << BLK_AW;
  localparam logic [MEM_AW-1:0] ROW_MASK = ~MEM_AW'(ROW_BYTES - 1);
  localparam logic [MEM_AW-1:0] BLK_MASK = ~MEM_AW'(BLK_BYTES - 1);

  logic [PTR_W-1:0]  ptr_q, ptr_d, step_nxt, acc_addr, upd_ptr;
  logic [DW-1:0]     latch_q, ram_q, hold_q, ram_wdata;
  logic              rd_pend_q, rd_oor_q;
  seq_state_e        state_q;
  logic [BLK_AW-1:0] cnt_q;
  logic [MEM_AW-1:0] base_q, ram_waddr;
  logic              tgt_ok_q, ram_we, seq_last, hold_clr;
  logic              op_go, op_rw, op_wr;
  op_kind_e          kind;
  byte_sel_e         sel;

  assign kind  = op_kind_e'(op_kind);
  assign sel   = byte_sel_e'(wr_sel);
  assign op_go = op_valid && (state_q == ST_IDLE);
  assign op_rw = op_go && (kind == OP_READ || kind == OP_WRITE);
  assign op_wr = op_go && (kind == OP_WRITE);

  tpl_ptr_step #(.PTR_W(PTR_W)) u_step (
    .cur  (ptr_q),
    .mode (upd_mode_e'(op_mode)),
    .acc  (acc_addr),
    .nxt  (step_nxt)
  );

  // pointer: auto-update first, then per-byte direct overrides
  always_comb begin
    upd_ptr = op_rw ? step_nxt : ptr_q;
    ptr_d   = upd_ptr;
    if (wr_en) begin
      unique case (sel)
        SEL_LOW:   ptr_d[7:0]        = wr_data;
        SEL_HIGH:  ptr_d[15:8]       = wr_data;
        SEL_UPPER: ptr_d[PTR_W-1:16] = wr_data[UP_W-1:0];
        default:   ptr_d             = upd_ptr;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ptr_q <= '0;
    else     ptr_q <= ptr_d;
  end

  // read path: memory returns data one clock after the request
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_pend_q <= 1'b0;
      rd_oor_q  <= 1'b0;
    end else begin
      rd_pend_q <= op_go && (kind == OP_READ);
      rd_oor_q  <= (acc_addr[PTR_W-1:MEM_AW] != '0);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                          latch_q <= '0;
    else if (wr_en && sel == SEL_LATCH) latch_q <= wr_data;
    else if (rd_pend_q)               latch_q <= rd_oor_q ? '1 : ram_q;
  end

  // commit / erase sequencer
  assign seq_last = (state_q == ST_ERASE  && cnt_q == BLK_AW'(BLK_BYTES - 1)) ||
                    (state_q == ST_COMMIT && cnt_q == BLK_AW'(ROW_BYTES - 1));
  assign hold_clr = (state_q == ST_COMMIT) && seq_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      base_q   <= '0;
      tgt_ok_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          cnt_q <= '0;
          if (op_go && kind == OP_ERASE) begin
            state_q  <= ST_ERASE;
            base_q   <= ptr_q[MEM_AW-1:0] & BLK_MASK;
            tgt_ok_q <= (ptr_q[PTR_W-1:MEM_AW] == '0);
          end else if (op_go && kind == OP_COMMIT) begin
            state_q  <= ST_COMMIT;
            base_q   <= ptr_q[MEM_AW-1:0] & ROW_MASK;
            tgt_ok_q <= (ptr_q[PTR_W-2:MEM_AW] == '0);
          end
        end
        default: begin
          cnt_q <= cnt_q + BLK_AW'(1);
          if (seq_last) state_q <= ST_IDLE;
        end
      endcase
    end
  end

  assign ram_we    = (state_q != ST_IDLE) && tgt_ok_q;
  assign ram_waddr = base_q | MEM_AW'(cnt_q);
  assign ram_wdata = (state_q == ST_ERASE) ? '1 : hold_q;

  tpl_ram #(.AW(MEM_AW), .DW(DW)) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .waddr (ram_waddr),
    .wdata (ram_wdata),
    .raddr (acc_addr[MEM_AW-1:0]),
    .rdata (ram_q)
  );

  tpl_hold_buf #(.IW(ROW_AW), .DW(DW)) u_hold (
    .clk   (clk),
    .rst   (rst),
    .clr   (hold_clr),
    .we    (op_wr),
    .widx  (acc_addr[ROW_AW-1:0]),
    .wdata (latch_q),
    .ridx  (cnt_q[ROW_AW-1:0]),
    .rdata (hold_q)
  );

  assign ptr_o   = ptr_q;
  assign latch_o = latch_q;
  assign busy_o  = (state_q != ST_IDLE);
endmodule

// File: rtl/tpl_checker.sv
module tpl_checker #(
  parameter int PTR_W = 22,
  parameter int DW    = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic [1:0]       wr_sel,
  input logic [7:0]       wr_data,
  input logic             op_valid,
  input logic [1:0]       op_kind,
  input logic [1:0]       op_mode,
  input logic [PTR_W-1:0] ptr_o,
  input logic [DW-1:0]    latch_o,
  input logic             busy_o
);
  localparam int LW = PTR_W - 1;

  logic rw_go;
  assign rw_go = op_valid && !busy_o && (op_kind == 2'd0 || op_kind == 2'd1);

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (ptr_o == '0 && latch_o == '0 && !busy_o));

  a_r2_latch_direct: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == 2'd3) |=> latch_o == $past(wr_data[DW-1:0]));

  a_r3_mode_none: assert property (@(posedge clk) disable iff (rst)
    (rw_go && op_mode == 2'd0 && !wr_en) |=> $stable(ptr_o));

  a_r3_post_inc: assert property (@(posedge clk) disable iff (rst)
    (rw_go && op_mode == 2'd1 && !wr_en) |=>
      ptr_o[LW-1:0] == LW'($past(ptr_o[LW-1:0]) + LW'(1)));

  a_r4_top_bit_kept: assert property (@(posedge clk) disable iff (rst)
    (rw_go && op_mode != 2'd0 && !(wr_en && wr_sel == 2'd2)) |=>
      ptr_o[PTR_W-1] == $past(ptr_o[PTR_W-1]));

  a_r8_busy_on_erase: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !busy_o && op_kind == 2'd3) |=> busy_o);

  a_r9_ignore_when_busy: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !wr_en) |=> $stable(ptr_o));

  a_r10_direct_low: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == 2'd0) |=> ptr_o[7:0] == $past(wr_data));
endmodule

bind tbl_access_unit tpl_checker #(.PTR_W(PTR_W), .DW(DW)) u_tpl_checker (
  .clk      (clk),
  .rst      (rst),
  .wr_en    (wr_en),
  .wr_sel   (wr_sel),
  .wr_data  (wr_data),
  .op_valid (op_valid),
  .op_kind  (op_kind),
  .op_mode  (op_mode),
  .ptr_o    (ptr_o),
  .latch_o  (latch_o),
  .busy_o   (busy_o)
);

// File: tb/tb_tbl_access_unit.sv
`timescale 1ns/1ps
module tb_tbl_access_unit;
  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en;
  logic [1:0]  wr_sel;
  logic [7:0]  wr_data;
  logic        op_valid;
  logic [1:0]  op_kind;
  logic [1:0]  op_mode;
  logic [21:0] ptr_o;
  logic [7:0]  latch_o;
  logic        busy_o;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  always #4 clk = ~clk;

  tbl_access_unit dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .op_valid(op_valid), .op_kind(op_kind), .op_mode(op_mode),
    .ptr_o(ptr_o), .latch_o(latch_o), .busy_o(busy_o)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: act=hung exp=done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic dwrite(input logic [1:0] s, input logic [7:0] d);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_ptr(input logic [21:0] v);
    dwrite(2'd0, v[7:0]);
    dwrite(2'd1, v[15:8]);
    dwrite(2'd2, {2'b00, v[21:16]});
  endtask

  task automatic do_op(input logic [1:0] k, input logic [1:0] m);
    op_valid = 1'b1; op_kind = k; op_mode = m;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy_o) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic read_at(input logic [21:0] a, output logic [7:0] v);
    set_ptr(a);
    do_op(2'd0, 2'd0);
    @(negedge clk);
    v = latch_o;
  endtask

  task automatic t_reset();
    chk("R1 ptr", 32'(ptr_o), 0);
    chk("R1 latch", 32'(latch_o), 0);
    chk("R1 busy", 32'(busy_o), 0);
  endtask

  task automatic t_direct();
    set_ptr(22'h2A_B3C4);
    chk("R2 pointer bytes", 32'(ptr_o), 32'h2AB3C4);
    dwrite(2'd3, 8'h5E);
    chk("R2 latch byte", 32'(latch_o), 32'h5E);
  endtask

  task automatic t_erase_block0();
    int n;
    logic [7:0] v;
    set_ptr(22'h0003C5);
    do_op(2'd3, 2'd0);
    chk("R8 busy after erase", 32'(busy_o), 1);
    wait_idle(n);
    chk("R8 erase length", 32'(n), 1024);
    read_at(22'h000000, v); chk("R8 erase first byte", 32'(v), 32'hFF);
    read_at(22'h0003FF, v); chk("R8 erase last byte", 32'(v), 32'hFF);
  endtask

  task automatic t_fill_commit();
    int n;
    logic [7:0] v;
    set_ptr(22'h000040);
    dwrite(2'd3, 8'h11); do_op(2'd1, 2'd1);
    chk("R3 post-inc write ptr", 32'(ptr_o), 32'h41);
    dwrite(2'd3, 8'h22); do_op(2'd1, 2'd1);
    dwrite(2'd3, 8'h33); do_op(2'd1, 2'd0);
    chk("R3 none write ptr", 32'(ptr_o), 32'h42);
    dwrite(2'd3, 8'h44); do_op(2'd1, 2'd3);
    chk("R3 pre-inc write ptr", 32'(ptr_o), 32'h43);
    set_ptr(22'h00007F);
    dwrite(2'd3, 8'h66); do_op(2'd1, 2'd2);
    chk("R3 post-dec write ptr", 32'(ptr_o), 32'h7E);
    set_ptr(22'h000047);
    do_op(2'd2, 2'd0);
    wait_idle(n);
    chk("R7 commit length", 32'(n), 64);
    read_at(22'h000040, v); chk("R6 slot 0", 32'(v), 32'h11);
    read_at(22'h000041, v); chk("R6 slot 1", 32'(v), 32'h22);
    read_at(22'h000042, v); chk("R6 slot 2", 32'(v), 32'h33);
    read_at(22'h000043, v); chk("R6 slot 3 via pre-inc", 32'(v), 32'h44);
    read_at(22'h000044, v); chk("R7 unwritten slot", 32'(v), 32'hFF);
    read_at(22'h00007F, v); chk("R7 last slot", 32'(v), 32'h66);
  endtask

  task automatic t_read_modes();
    set_ptr(22'h000040);
    do_op(2'd0, 2'd3);
    chk("R3 pre-inc read ptr", 32'(ptr_o), 32'h41);
    @(negedge clk);
    chk("R5 pre-inc read data", 32'(latch_o), 32'h22);
    set_ptr(22'h000042);
    do_op(2'd0, 2'd2);
    chk("R3 post-dec read ptr", 32'(ptr_o), 32'h41);
    @(negedge clk);
    chk("R5 post-dec read data", 32'(latch_o), 32'h33);
    set_ptr(22'h000043);
    do_op(2'd0, 2'd1);
    chk("R3 post-inc read ptr", 32'(ptr_o), 32'h44);
    @(negedge clk);
    chk("R5 post-inc read data", 32'(latch_o), 32'h44);
  endtask

  task automatic t_out_of_range();
    logic [7:0] v;
    read_at(22'h200040, v); chk("R5 bit21 set reads FF", 32'(v), 32'hFF);
    read_at(22'h000840, v); chk("R5 bit11 set reads FF", 32'(v), 32'hFF);
  endtask

  task automatic t_wrap();
    set_ptr(22'h1FFFFF); do_op(2'd0, 2'd1);
    chk("R4 inc wraps", 32'(ptr_o), 32'h000000);
    set_ptr(22'h200000); do_op(2'd1, 2'd2);
    chk("R4 dec wraps keeps bit21", 32'(ptr_o), 32'h3FFFFF);
    set_ptr(22'h3FFFFF); do_op(2'd0, 2'd3);
    chk("R4 pre-inc wraps keeps bit21", 32'(ptr_o), 32'h200000);
    @(negedge clk);
  endtask

  task automatic t_hold_reset();
    int n;
    logic [7:0] v;
    set_ptr(22'h000040);
    do_op(2'd2, 2'd0);
    wait_idle(n);
    read_at(22'h000041, v); chk("R7 holding back to FF", 32'(v), 32'hFF);
    read_at(22'h00007F, v); chk("R7 holding top back to FF", 32'(v), 32'hFF);
  endtask

  task automatic t_busy_ignore();
    int n;
    logic [7:0] v;
    set_ptr(22'h0004A5);
    do_op(2'd3, 2'd0);
    do_op(2'd0, 2'd1);
    chk("R9 op ignored while busy", 32'(ptr_o), 32'h0004A5);
    dwrite(2'd0, 8'h10);
    chk("R9 direct write while busy", 32'(ptr_o), 32'h000410);
    wait_idle(n);
    read_at(22'h0007FF, v); chk("R8 block 1 erased", 32'(v), 32'hFF);
  endtask

  task automatic t_priority();
    set_ptr(22'h0000FF);
    op_valid = 1'b1; op_kind = 2'd0; op_mode = 2'd1;
    wr_en = 1'b1; wr_sel = 2'd0; wr_data = 8'h10;
    @(negedge clk);
    op_valid = 1'b0; wr_en = 1'b0;
    chk("R10 direct byte over auto-update", 32'(ptr_o), 32'h000110);
    @(negedge clk);
  endtask

  initial begin
    rst = 1'b1; wr_en = 1'b0; wr_sel = '0; wr_data = '0;
    op_valid = 1'b0; op_kind = '0; op_mode = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_direct();
    t_erase_block0();
    t_fill_commit();
    t_read_modes();
    t_out_of_range();
    t_wrap();
    t_hold_reset();
    t_busy_ignore();
    t_priority();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule